// File: doc/BRIEF.md
# Parallel Port Transmit Engine

This block is the sending side of a synchronous parallel streaming link. It takes words from one or two on-chip valid/ready sources, channel I and channel Q, and places them on a word-wide DATA bus. Three control signals go with the bus: a word-valid strobe, a START marker and a link clock. The link clock comes from dividing the system clock. The receiver can pause the stream with a WAIT input. Each control signal has its own polarity setting.

There are two modes. In single-channel mode only channel I is read, and START marks the first word of each line. The line length is a configuration input. In interleave mode the link carries I and Q words in turn, always as an I-then-Q pair. START then flags every I word. A new word is launched one system clock after the active link-clock edge. The receiver samples on the next active edge.

Back-pressure on the sources: a word moves only in a system cycle where both `ch_x_valid` and `ch_x_ready` are high. Ready is high only in the one system cycle that launches a word, and it may depend on valid. A source must hold valid and data steady until the handshake completes. WAIT stops new launches. In interleave mode, an I/Q pair stays back until both sources show valid.

Top module: `ppt_tx`

## Requirements
- R1: The link clock period is 2×(cfg_div+1) system cycles with equal high and low halves. When cfg_clk_inv=0 the active edge is the rising edge; cfg_clk_inv=1 inverts `link_clk`, so the falling edge becomes active.
- R2: Words, START and ENABLE change only one system cycle after an active link-clock edge. They hold steady until the next launch, so each word is seen at exactly one active edge.
- R3: ENABLE is always driven. It is asserted only during link-clock cycles that carry a new word. While no word is sent, DATA keeps its last value and ENABLE sits at its inactive level, including just after reset.
- R4: In single-channel mode, channel I words go out in arrival order. START is asserted with the first word of every line of cfg_line_len words, and cfg_line_len=0 counts as 1.
- R5: WAIT passes through a two-flop synchronizer. While the synchronized WAIT is active and cfg_wait_en=1, no word is launched. Sending resumes on the next launch after release, and no word is lost or repeated.
- R6: With cfg_wait_en=0 the WAIT pin has no effect on the stream.
- R7: The polarity bits cfg_en_inv, cfg_start_inv and cfg_wait_inv invert ENABLE, START and WAIT, where 0 means active-high. DATA is never inverted.
- R8: In interleave mode (cfg_ilv=1), words alternate I, Q, I, Q starting with I. START is asserted on every I word and on no Q word.
- R9: In interleave mode, an I word is taken only while channel Q also shows valid. Otherwise no ready is raised, and ENABLE and START stay inactive.
- R10: In single-channel mode ch_q_ready stays low, and channel Q words are never sent.
- R11: Each ready pulse takes exactly one word from one channel, and only in a launch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Divider setting N; link period is 2×(N+1) clocks |
| cfg_line_len | input | LINE_W | Words per line in single-channel mode (0 counts as 1) |
| cfg_ilv | input | 1 | 1 selects the I/Q interleave mode |
| cfg_wait_en | input | 1 | 1 makes WAIT pause the stream |
| cfg_en_inv | input | 1 | Inverts ENABLE |
| cfg_start_inv | input | 1 | Inverts START |
| cfg_wait_inv | input | 1 | WAIT is active-low when 1 |
| cfg_clk_inv | input | 1 | Inverts the link clock (falling edge active) |
| ch_i_valid | input | 1 | Channel I word available |
| ch_i_ready | output | 1 | Channel I word taken this cycle |
| ch_i_data | input | DATA_W | Channel I word |
| ch_q_valid | input | 1 | Channel Q word available |
| ch_q_ready | output | 1 | Channel Q word taken this cycle |
| ch_q_data | input | DATA_W | Channel Q word |
| link_wait | input | 1 | Pause request from the receiver (asynchronous) |
| link_clk | output | 1 | Link clock |
| link_start | output | 1 | Line-start or I-word marker |
| link_enable | output | 1 | Word-valid strobe |
| link_data | output | DATA_W | Link data bus |

## Verification
The assertions check on every cycle that:
- launches follow the divider's active phase;
- outputs hold between launches;
- a synchronized WAIT blocks the next launch;
- ready pulses happen only in launch cycles;
- channel Q is never read in single-channel mode;
- an I word is never taken without a Q word behind it.

Other properties can only be shown by the bench's scenarios, which model a receiver sampling at each active edge:
- the link clock period and duty cycle;
- word order and START placement over whole lines and I/Q pairs;
- loss-free resumption after WAIT;
- the effect of each polarity bit seen at the pins.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  // Which channel supplies the next word in interleave mode.
  typedef enum logic {
    SEL_I = 1'b0,
    SEL_Q = 1'b1
  } ppt_sel_e;

  // Number of synchronizer flops on the pause input.
  localparam int unsigned PPT_SYNC_STAGES = 2;
endpackage

// File: rtl/ppt_clkdiv.sv
module ppt_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             phase,
  output logic             launch
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;
  logic             rise;

  // Each half period lasts cfg_div+1 system cycles.
  assign wrap = (cnt >= cfg_div);
  assign rise = wrap && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phase  <= 1'b0;
      launch <= 1'b0;
    end else begin
      // Launch one cycle after the active edge so that the edge comes first.
      launch <= rise;
      if (wrap) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R2: a launch always falls in the active half of the link clock.
  p_launch_in_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> phase);
endmodule

// File: rtl/ppt_wait_sync.sv
module ppt_wait_sync
  import ppt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_wait,
  input  logic cfg_wait_en,
  input  logic cfg_wait_inv,
  output logic stall
);
  logic [PPT_SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      // Start from the released level of the configured polarity.
      sync_q <= {PPT_SYNC_STAGES{cfg_wait_inv}};
    end else begin
      sync_q <= {sync_q[PPT_SYNC_STAGES-2:0], link_wait};
    end
  end

  assign stall = cfg_wait_en && (sync_q[PPT_SYNC_STAGES-1] ^ cfg_wait_inv);
endmodule

// File: rtl/ppt_seq.sv
module ppt_seq
  import ppt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              stall,
  input  logic              cfg_ilv,
  input  logic [LINE_W-1:0] cfg_line_len,
  input  logic              ch_i_valid,
  output logic              ch_i_ready,
  input  logic [DATA_W-1:0] ch_i_data,
  input  logic              ch_q_valid,
  output logic              ch_q_ready,
  input  logic [DATA_W-1:0] ch_q_data,
  output logic [DATA_W-1:0] word_data,
  output logic              word_start,
  output logic              word_en
);
  ppt_sel_e          sel;
  logic [LINE_W-1:0] wcnt;
  logic [LINE_W-1:0] last_idx;
  logic              take_i;
  logic              take_q;

  assign last_idx = (cfg_line_len == '0) ? '0 : cfg_line_len - LINE_W'(1);

  always_comb begin
    take_i = 1'b0;
    take_q = 1'b0;
    if (launch && !stall) begin
      if (cfg_ilv) begin
        if (sel == SEL_I) take_i = ch_i_valid && ch_q_valid;
        else              take_q = ch_q_valid;
      end else begin
        take_i = ch_i_valid;
      end
    end
  end

  assign ch_i_ready = take_i;
  assign ch_q_ready = take_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= SEL_I;
      wcnt       <= '0;
      word_data  <= '0;
      word_start <= 1'b0;
      word_en    <= 1'b0;
    end else if (launch) begin
      word_en    <= take_i || take_q;
      word_start <= cfg_ilv ? take_i : (take_i && (wcnt == '0));
      if (take_i) word_data <= ch_i_data;
      if (take_q) word_data <= ch_q_data;
      if (take_i && cfg_ilv) sel <= SEL_Q;
      if (take_q)            sel <= SEL_I;
      if (take_i && !cfg_ilv) wcnt <= (wcnt >= last_idx) ? '0 : wcnt + LINE_W'(1);
    end
  end

  // R11: sources are read only in launch cycles.
  p_pop_on_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_i_ready || ch_q_ready) |-> launch);
  // R11: one word per launch.
  p_one_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_i_ready && ch_q_ready));
  // R5: a synchronized pause blocks the launch it meets.
  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && stall) |=> !word_en);
  // R2: outputs hold between launches.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(word_data) && $stable(word_en) && $stable(word_start)));
  // R3: a start marker never appears without a word.
  p_start_with_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> word_en);
  // R10: channel Q is untouched in single-channel mode.
  p_q_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ilv |-> !ch_q_ready);
  // R9: an I word leaves only with its Q partner waiting.
  p_pair_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ilv && ch_i_ready) |-> ch_q_valid);
endmodule

// File: rtl/ppt_tx.sv
module ppt_tx #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LINE_W-1:0] cfg_line_len,
  input  logic              cfg_ilv,
  input  logic              cfg_wait_en,
  input  logic              cfg_en_inv,
  input  logic              cfg_start_inv,
  input  logic              cfg_wait_inv,
  input  logic              cfg_clk_inv,
  input  logic              ch_i_valid,
  output logic              ch_i_ready,
  input  logic [DATA_W-1:0] ch_i_data,
  input  logic              ch_q_valid,
  output logic              ch_q_ready,
  input  logic [DATA_W-1:0] ch_q_data,
  input  logic              link_wait,
  output logic              link_clk,
  output logic              link_start,
  output logic              link_enable,
  output logic [DATA_W-1:0] link_data
);
  logic              phase;
  logic              launch;
  logic              stall;
  logic [DATA_W-1:0] word_data;
  logic              word_start;
  logic              word_en;

  ppt_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_div (cfg_div),
    .phase   (phase),
    .launch  (launch)
  );

  ppt_wait_sync u_wsync (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_wait    (link_wait),
    .cfg_wait_en  (cfg_wait_en),
    .cfg_wait_inv (cfg_wait_inv),
    .stall        (stall)
  );

  ppt_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .stall        (stall),
    .cfg_ilv      (cfg_ilv),
    .cfg_line_len (cfg_line_len),
    .ch_i_valid   (ch_i_valid),
    .ch_i_ready   (ch_i_ready),
    .ch_i_data    (ch_i_data),
    .ch_q_valid   (ch_q_valid),
    .ch_q_ready   (ch_q_ready),
    .ch_q_data    (ch_q_data),
    .word_data    (word_data),
    .word_start   (word_start),
    .word_en      (word_en)
  );

  assign link_clk    = phase ^ cfg_clk_inv;
  assign link_enable = word_en ^ cfg_en_inv;
  assign link_start  = word_start ^ cfg_start_inv;
  assign link_data   = word_data;

  // R3: a word-valid strobe only follows a launch or holds one.
  p_en_after_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_en) |-> $past(launch));
endmodule

// File: tb/ppt_tx_test.sv
`timescale 1ns/1ps
module ppt_tx_test;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  cfg_div = 8'd1;
  logic [11:0] cfg_line_len = 12'd4;
  logic cfg_ilv = 0, cfg_wait_en = 1, cfg_en_inv = 0, cfg_start_inv = 0;
  logic cfg_wait_inv = 0, cfg_clk_inv = 0, link_wait = 0;
  logic ch_i_ready, ch_q_ready, link_clk, link_start, link_enable;
  logic [DW-1:0] link_data, ch_i_data, ch_q_data;
  logic ch_i_valid, ch_q_valid;

  logic [DW-1:0] src_i [64];
  logic [DW-1:0] src_q [64];
  int n_i = 0, n_q = 0, pi = 0, pq = 0;
  logic [DW-1:0] cap_d [64];
  logic          cap_s [64];
  int cap_n = 0;
  int tests = 0, fails = 0;

  assign ch_i_valid = rst_n && (pi < n_i);
  assign ch_q_valid = rst_n && (pq < n_q);
  assign ch_i_data  = src_i[pi[5:0]];
  assign ch_q_data  = src_q[pq[5:0]];

  ppt_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_line_len(cfg_line_len),
    .cfg_ilv(cfg_ilv), .cfg_wait_en(cfg_wait_en), .cfg_en_inv(cfg_en_inv),
    .cfg_start_inv(cfg_start_inv), .cfg_wait_inv(cfg_wait_inv),
    .cfg_clk_inv(cfg_clk_inv), .ch_i_valid(ch_i_valid), .ch_i_ready(ch_i_ready),
    .ch_i_data(ch_i_data), .ch_q_valid(ch_q_valid), .ch_q_ready(ch_q_ready),
    .ch_q_data(ch_q_data), .link_wait(link_wait), .link_clk(link_clk),
    .link_start(link_start), .link_enable(link_enable), .link_data(link_data)
  );

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Source model: count a handshake seen mid-cycle, advance after the edge.
  initial begin
    forever begin
      logic ti, tq;
      @(negedge clk);
      ti = ch_i_valid && ch_i_ready;
      tq = ch_q_valid && ch_q_ready;
      @(posedge clk);
      #1;
      if (ti) pi++;
      if (tq) pq++;
    end
  end

  // Receiver model: sample at every active link-clock edge.
  initial begin
    logic prev_act;
    prev_act = 1'b0;
    forever begin
      logic act;
      @(negedge clk);
      act = link_clk ^ cfg_clk_inv;
      if (!rst_n) prev_act = 1'b0;
      else begin
        if (act && !prev_act && ((link_enable ^ cfg_en_inv) == 1'b1) && cap_n < 64) begin
          cap_d[cap_n] = link_data;
          cap_s[cap_n] = link_start ^ cfg_start_inv;
          cap_n++;
        end
        prev_act = act;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    n_i = 0; n_q = 0; pi = 0; pq = 0; cap_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic load_i(input int n, input int base);
    for (int k = 0; k < n; k++) src_i[k] = DW'(base + k * 3);
    n_i = n;
  endtask

  task automatic load_q(input int n, input int base);
    for (int k = 0; k < n; k++) src_q[k] = DW'(base + k * 5);
    n_q = n;
  endtask

  task automatic t_reset();
    cfg_en_inv = 1; cfg_start_inv = 1; cfg_clk_inv = 1;
    do_reset();
    @(negedge clk);
    chk("R3 idle enable after reset", link_enable, 1);
    chk("R7 idle start after reset", link_start, 1);
    chk("R1 link clock idle level", link_clk, 1);
    chk("R11 no ready after reset", ch_i_ready, 0);
    cfg_en_inv = 0; cfg_start_inv = 0; cfg_clk_inv = 0;
  endtask

  task automatic measure(input int div);
    int per, hi;
    cfg_div = 8'(div);
    do_reset();
    @(negedge clk);
    while (link_clk !== 1'b0) @(negedge clk);
    while (link_clk !== 1'b1) @(negedge clk);
    per = 0; hi = 0;
    do begin
      if (link_clk) hi++;
      per++;
      @(negedge clk);
    end while (!(link_clk == 1'b1 && hi != per));
    chk("R1 link period", per, 2 * (div + 1));
    chk("R1 link high half", hi, div + 1);
  endtask

  task automatic t_single(input int len, input int n);
    int exp_len;
    cfg_div = 8'd1; cfg_ilv = 0; cfg_line_len = 12'(len);
    do_reset();
    load_i(n, 100);
    load_q(4, 900);
    repeat (n * 4 + 40) @(posedge clk);
    exp_len = (len == 0) ? 1 : len;
    chk("R4 word count", cap_n, n);
    chk("R11 words taken", pi, n);
    chk("R10 channel Q untouched", pq, 0);
    for (int k = 0; k < n; k++) begin
      chk("R4 word order", cap_d[k], 100 + k * 3);
      chk("R4 start placement", cap_s[k], (k % exp_len) == 0);
    end
  endtask

  task automatic t_wait();
    int held;
    cfg_div = 8'd1; cfg_ilv = 0; cfg_line_len = 12'd100; cfg_wait_en = 1;
    do_reset();
    load_i(20, 7);
    repeat (14) @(posedge clk);
    link_wait = 1'b1;
    repeat (16) @(posedge clk);
    held = cap_n;
    repeat (100) @(posedge clk);
    chk("R5 no words while paused", cap_n, held);
    chk("R5 pause took effect", (held > 0 && held < 20), 1);
    @(negedge clk);
    chk("R3 enable idle while paused", link_enable, 0);
    link_wait = 1'b0;
    repeat (120) @(posedge clk);
    chk("R5 all words after release", cap_n, 20);
    for (int k = 0; k < 20; k++) chk("R5 order after resume", cap_d[k], 7 + k * 3);
  endtask

  task automatic t_wait_off();
    cfg_wait_en = 0; link_wait = 1'b1;
    do_reset();
    load_i(6, 40);
    repeat (60) @(posedge clk);
    chk("R6 WAIT ignored when disabled", cap_n, 6);
    link_wait = 1'b0; cfg_wait_en = 1;
  endtask

  task automatic t_wait_inv();
    cfg_wait_inv = 1; link_wait = 1'b0;
    do_reset();
    load_i(5, 60);
    repeat (80) @(posedge clk);
    chk("R7 low WAIT pauses when inverted", cap_n, 0);
    link_wait = 1'b1;
    repeat (60) @(posedge clk);
    chk("R7 high WAIT releases when inverted", cap_n, 5);
    cfg_wait_inv = 0; link_wait = 1'b0;
  endtask

  task automatic t_polarity();
    cfg_en_inv = 1; cfg_start_inv = 1; cfg_clk_inv = 1;
    cfg_div = 8'd2; cfg_line_len = 12'd2; cfg_ilv = 0;
    do_reset();
    load_i(4, 300);
    repeat (80) @(posedge clk);
    chk("R7 words under inverted controls", cap_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R7 data not inverted", cap_d[k], 300 + k * 3);
      chk("R7 start under inversion", cap_s[k], (k % 2) == 0);
    end
    @(negedge clk);
    chk("R7 inverted idle enable", link_enable, 1);
    cfg_en_inv = 0; cfg_start_inv = 0; cfg_clk_inv = 0;
  endtask

  task automatic t_ilv();
    cfg_div = 8'd0; cfg_ilv = 1;
    do_reset();
    load_i(5, 10);
    load_q(5, 500);
    repeat (80) @(posedge clk);
    chk("R8 interleaved count", cap_n, 10);
    for (int k = 0; k < 10; k++) begin
      chk("R8 I/Q alternation", cap_d[k], (k % 2 == 0) ? 10 + (k / 2) * 3 : 500 + (k / 2) * 5);
      chk("R8 start on I words", cap_s[k], (k % 2) == 0);
    end
  endtask

  task automatic t_ilv_hold();
    cfg_div = 8'd1; cfg_ilv = 1;
    do_reset();
    load_i(3, 20);
    repeat (60) @(posedge clk);
    chk("R9 nothing sent without Q", cap_n, 0);
    chk("R9 no I word taken alone", pi, 0);
    @(negedge clk);
    chk("R9 start idle while held", link_start, 0);
    load_q(3, 700);
    repeat (80) @(posedge clk);
    chk("R9 pairs sent once Q arrives", cap_n, 6);
    chk("R9 first word is I", cap_d[0], 20);
    chk("R9 second word is Q", cap_d[1], 700);
    cfg_ilv = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    measure(2);
    measure(0);
    t_single(4, 10);
    t_single(0, 5);
    t_wait();
    t_wait_off();
    t_wait_inv();
    t_polarity();
    t_ilv();
    t_ilv_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule